// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is a memory-mapped GPIO port for one bank of 32 pins. Software reaches it over a simple 32-bit register bus that has a byte address, a write strobe, a read strobe, write data and registered read data. The port holds an output level and a drive-enable for every pin. It also returns the pin levels as seen from outside, after they pass through a two-flop synchronizer. A constant identifier word can be read so that software can tell which variant of the port it is talking to.

The output-level register and the drive-enable register are each split into two 16-bit halves, and each half has its own word address. Every write to a half carries its own per-bit write enables: the top 16 bits of the write word select which of the low 16 data bits are stored. Software can therefore set or clear any group of pins in one bus write, with no read-modify-write sequence and no lock. The bus is a plain control interface with no back-pressure. A write takes effect at the clock edge that samples it. A read returns its word one cycle after the edge that samples the read strobe, and that word is held until the next read.

Top module: `gpio_mhw_port`

## Requirements
- R1: While reset (rst_n low, synchronous) is active, all output-level bits, all drive-enable bits, all synchronizer stages and bus_rdata are cleared to 0, so every pin starts as an undriven input.
- R2: On a write to a control half, data bit i (0..15) is stored only when bit i+16 of bus_wdata is 1. Every other bit of that half keeps its value, so a write with all enable bits 0 changes nothing.
- R3: The control halves sit at byte offsets 0x00 (output level, pins 0..15), 0x04 (output level, pins 16..31), 0x08 (drive enable, pins 0..15) and 0x0C (drive enable, pins 16..31). pin_out and pin_oe show a write from the clock edge that samples it.
- R4: A read of a control half returns its 16 stored bits in bus_rdata[15:0], with bus_rdata[31:16] equal to 0.
- R5: A drive-enable bit of 1 makes its pin an output (pin_oe bit 1). A bit of 0 makes it an input (pin_oe bit 0).
- R6: A read of offset 0x70 returns pin_in through a two-flop synchronizer, one bit per pin. A pin change applied before edge E is returned by a read sampled at edge E+2, while reads sampled at E and E+1 still return the old level.
- R7: A read of offset 0x78 returns the constant 0x0101157C. Writes to that offset have no effect.
- R8: Writes to any offset other than the four control halves, including unaligned addresses, offset 0x70 and offset 0x78, change no state. Reads of unmapped offsets return 0.
- R9: bus_rdata is loaded at the clock edge that samples bus_rd and holds its value while bus_rd is low. A read and a write to the same half in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Registered read word |
| pin_in | input | PINS (32) | Asynchronous external pin levels |
| pin_out | output | PINS (32) | Output level per pin |
| pin_oe | output | PINS (32) | Drive enable per pin, 1 = output |

## Verification
A write is due at pin_out or pin_oe at the edge that samples bus_wr, so the bench checks those pins at the falling edge that follows. A read word is due one edge after bus_rd is sampled. The driver queues its expectation at the moment it raises bus_rd, and the monitor compares it at the next falling edge. Pin input levels take two more edges to reach a read, so the bench issues three reads back to back, starting at the edge where a pin change is first sampled, and expects the old, old and new values.

// File: rtl/gpio_mhw_pkg.sv
package gpio_mhw_pkg;
  localparam int HALF_W      = 16;
  localparam int BUS_W       = 2 * HALF_W;
  localparam int HALF_STRIDE = 4;          // byte distance between halves
  localparam int PINS_OFS    = 'h70;       // synchronized pin levels
  localparam int VER_OFS     = 'h78;       // identifier word
  localparam logic [BUS_W-1:0] VERSION_ID = 32'h0101_157C;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_mhw_half.sv
module gpio_mhw_half
  import gpio_mhw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [BUS_W-1:0]  wdata,
  output logic [HALF_W-1:0] q
);
  logic [HALF_W-1:0] bit_en;
  logic [HALF_W-1:0] bit_val;
  logic [HALF_W-1:0] q_next;

  assign bit_en  = wdata[BUS_W-1:HALF_W];
  assign bit_val = wdata[HALF_W-1:0];
  assign q_next  = (q & ~bit_en) | (bit_val & bit_en);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= q_next;
  end
endmodule

// File: rtl/gpio_mhw_sync.sv
module gpio_mhw_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_mhw_rdmux.sv
module gpio_mhw_rdmux
  import gpio_mhw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NHALF  = 4,
  parameter int PINS   = 32
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NHALF*HALF_W-1:0] ctrl_flat,
  input  logic [PINS-1:0]         pins_sync,
  output logic [BUS_W-1:0]        word
);
  always_comb begin
    word = '0;
    for (int k = 0; k < NHALF; k++) begin
      if (addr == ADDR_W'(k * HALF_STRIDE))
        word = BUS_W'(ctrl_flat[k*HALF_W +: HALF_W]);
    end
    if (addr == ADDR_W'(PINS_OFS)) word = BUS_W'(pins_sync);
    if (addr == ADDR_W'(VER_OFS))  word = VERSION_ID;
  end
endmodule

// File: rtl/gpio_mhw_port.sv
module gpio_mhw_port
  import gpio_mhw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PINS   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  localparam int HALVES_PER_REG = PINS / HALF_W;
  localparam int NHALF          = 2 * HALVES_PER_REG;

  logic [NHALF*HALF_W-1:0] ctrl_flat;
  logic [PINS-1:0]         pins_sync;
  logic [BUS_W-1:0]        rd_word;

  // Halves 0..HALVES_PER_REG-1 hold output levels, the rest drive enables.
  for (genvar k = 0; k < NHALF; k++) begin : g_half
    logic hit;
    assign hit = bus_wr && (bus_addr == ADDR_W'(k * HALF_STRIDE));
    gpio_mhw_half u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit),
      .wdata  (bus_wdata),
      .q      (ctrl_flat[k*HALF_W +: HALF_W])
    );
  end

  assign pin_out = ctrl_flat[PINS-1:0];
  assign pin_oe  = ctrl_flat[2*PINS-1:PINS];

  gpio_mhw_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  gpio_mhw_rdmux #(.ADDR_W(ADDR_W), .NHALF(NHALF), .PINS(PINS)) u_rdmux (
    .addr      (bus_addr),
    .ctrl_flat (ctrl_flat),
    .pins_sync (pins_sync),
    .word      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/gpio_mhw_chk.sv
module gpio_mhw_chk
  import gpio_mhw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PINS   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe
);
  logic out_wr, dir_wr;
  assign out_wr = bus_wr && (bus_addr == ADDR_W'(0) ||
                             bus_addr == ADDR_W'(HALF_STRIDE));
  assign dir_wr = bus_wr && (bus_addr == ADDR_W'(2*HALF_STRIDE) ||
                             bus_addr == ADDR_W'(3*HALF_STRIDE));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=>
      pin_out[HALF_W-1:0] ==
        (($past(pin_out[HALF_W-1:0]) & ~$past(bus_wdata[BUS_W-1:HALF_W])) |
         ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[BUS_W-1:HALF_W]))));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr |=> $stable(pin_out));

  assert_dir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(pin_oe));

  assert_half_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(2*HALF_STRIDE)) |=>
      bus_rdata == BUS_W'($past(pin_oe[HALF_W-1:0])));

  assert_version_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(VER_OFS)) |=> bus_rdata == VERSION_ID);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_mhw_port gpio_mhw_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_mhw_port.sv
module sim_gpio_mhw_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mhw_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver tasks: called at a falling edge, return at the next one.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: a read sampled at a rising edge is compared at the next falling edge.
  initial begin
    forever begin
      bit pending;
      @(posedge clk);
      pending = bus_rd && rst_n;
      @(negedge clk);
      if (pending) begin
        if (exp_q.size() == 0) check("monitor underflow", bus_rdata, 32'hx);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", pin_out, 32'h0);
    check("R1 pin_oe in reset", pin_oe, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 out lo after reset", 8'h00, 32'h0);
    rd("R1 dir hi after reset", 8'h0C, 32'h0);
    rd("R1 pins after reset", 8'h70, 32'h0);

    // R2 / R3: masked writes to the output level halves
    wr(8'h00, 32'hFFFF_A5A5);
    check("R3 out lo full write", pin_out, 32'h0000_A5A5);
    wr(8'h00, 32'h00F0_0F0F);
    check("R2 partial mask clears bits 4-7", pin_out, 32'h0000_A505);
    wr(8'h00, 32'h0000_FFFF);
    check("R2 zero mask changes nothing", pin_out, 32'h0000_A505);
    wr(8'h04, 32'hFFFF_1234);
    check("R3 out hi write", pin_out, 32'h1234_A505);
    check("R5 oe untouched by out write", pin_oe, 32'h0);
    rd("R4 out hi read", 8'h04, 32'h0000_1234);
    rd("R4 out lo read", 8'h00, 32'h0000_A505);

    // R5: drive enables
    wr(8'h08, 32'h8001_FFFF);
    check("R5 dir lo write", pin_oe, 32'h0000_8001);
    wr(8'h0C, 32'h0003_0002);
    check("R5 dir hi masked write", pin_oe, 32'h0002_8001);
    check("R3 out untouched by dir write", pin_out, 32'h1234_A505);
    rd("R4 dir hi read", 8'h0C, 32'h0000_0002);
    rd("R4 dir lo read", 8'h08, 32'h0000_8001);

    // R7: identifier
    rd("R7 version", 8'h78, 32'h0101_157C);
    wr(8'h78, 32'hFFFF_FFFF);
    rd("R7 version after write", 8'h78, 32'h0101_157C);

    // R8: unmapped writes and reads
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h0E, 32'hFFFF_FFFF);
    check("R8 out unchanged by unmapped writes", pin_out, 32'h1234_A505);
    check("R8 oe unchanged by unmapped writes", pin_oe, 32'h0002_8001);
    rd("R8 unmapped read 0x10", 8'h10, 32'h0);
    rd("R8 unmapped read 0x7C", 8'h7C, 32'h0);

    // R6: synchronizer latency
    repeat (3) @(negedge clk);
    rd("R6 pins idle", 8'h70, 32'h0);
    pin_in = 32'hDEAD_BEEF;
    rd("R6 pins edge E", 8'h70, 32'h0);
    rd("R6 pins edge E+1", 8'h70, 32'h0);
    rd("R6 pins edge E+2", 8'h70, 32'hDEAD_BEEF);
    pin_in = 32'h0F0F_1234;
    repeat (3) @(negedge clk);
    rd("R6 pins second pattern", 8'h70, 32'h0F0F_1234);

    // R9: hold and read-during-write ordering
    rd("R9 read before hold", 8'h00, 32'h0000_A505);
    repeat (3) @(negedge clk);
    check("R9 rdata held while idle", bus_rdata, 32'h0000_A505);
    bus_addr = 8'h00; bus_wdata = 32'hFFFF_0000; bus_wr = 1'b1; bus_rd = 1'b1;
    exp_q.push_back(32'h0000_A505); tag_q.push_back("R9 read during write");
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R2 write alongside read", pin_out, 32'h1234_0000);
    rd("R9 read after write", 8'h00, 32'h0);

    repeat (2) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule